// File: doc/BRIEF.md
# Serial Frame Clock-Count Write Guard

This block sits beside the instruction decoder of a serial memory slave. It counts how many serial clock rising edges arrive between the start bit of an instruction and the moment chip select is released. Every instruction that changes stored contents has one exact frame length. If a noise pulse adds a clock edge, the address and data move by one bit position and the frame comes out one edge too long. A missing edge makes it one edge too short. In both cases the count no longer matches the expected length.

When chip select falls, the guard works out the expected length for the decoded instruction and compares it with the edges it counted. It then sends exactly one pulse to the programming sequencer. A commit pulse lets the write go ahead. An abort pulse means the sequencer must leave memory untouched. Reads and other commands that change no contents get no pulse at all. The decoder and the sequencer do the rest.

Top module: `frame_len_guard`

## Requirements
- R1: A start strobe opens a frame with the count at 1, because the start-bit edge counts as the first clock. Each later clock strobe adds one while the frame is open. Clock strobes and chip-select-fall strobes that arrive while no frame is open have no effect and produce no output.
- R2: A single-word write (op_class 1) gets commit_o only when the frame holds exactly 27 clock edges. Any other count gets abort_o.
- R3: A fill-all write (op_class 2) gets commit_o only when the frame holds exactly 27 clock edges. Any other count gets abort_o.
- R4: A page write (op_class 3) with page_words = k carries N = k+1 words. It gets commit_o only when the frame holds exactly 11 + 16·N edges (27, 43, 59 or 75). Any other count gets abort_o.
- R5: A guard-register write (op_class 4) and a guard-register clear (op_class 5) each get commit_o only when the frame holds exactly 11 edges. Any other count gets abort_o.
- R6: On a length mismatch for a modifying class, abort_o pulses and commit_o stays low.
- R7: The non-modifying classes (op_class 0, 6 and 7) produce neither commit_o nor abort_o, whatever the count.
- R8: The edge counter stops at its all-ones value and never wraps. A frame that is far too long is therefore aborted; it can never land back on a valid length.
- R9: commit_o and abort_o are never high together. Each is a pulse one cycle wide, and it appears in the cycle after the clock edge that samples the chip-select-fall strobe. That strobe closes the frame. Both outputs are low during reset and after it.
- R10: A clock strobe that arrives in the same cycle as the chip-select-fall strobe is included in the count that gets compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_stb | input | 1 | Start bit detected; this is also the first serial clock edge |
| sclk_stb | input | 1 | Serial clock rising-edge event |
| cs_fall_stb | input | 1 | Chip-select falling-edge event |
| op_class | input | 3 | Decoded instruction class, valid with cs_fall_stb |
| page_words | input | 2 | Page write word count minus one, valid with cs_fall_stb |
| commit_o | output | 1 | One-cycle go pulse to the programming sequencer |
| abort_o | output | 1 | One-cycle abort pulse to the programming sequencer |

## Verification
The bench builds the guard with its default parameters: 2 opcode bits, 8 address bits, 16 data bits and up to 4 words per page. That gives frame lengths of 11, 27, 43, 59 and 75 and a 7-bit counter that stops at 127. With these values every page size can be reached by exact-length, one-short and one-long frames. A 203-edge frame would wrap onto the valid 75-edge length if the counter rolled over, so running one shows that saturation is working. Clock strobes sent outside a frame, and a clock edge that falls in the same cycle as chip select, are also within reach.

// File: rtl/flg_pkg.sv
`timescale 1ns/1ps
// Package: shared instruction-class encoding for the frame length guard.
// Assumes the decoder presents these class codes on a 3-bit bus.
package flg_pkg;

    typedef enum logic [2:0] {
        OPC_OTHER    = 3'd0,
        OPC_WORD_WR  = 3'd1,
        OPC_FILL_WR  = 3'd2,
        OPC_PAGE_WR  = 3'd3,
        OPC_GREG_WR  = 3'd4,
        OPC_GREG_CLR = 3'd5,
        OPC_RSV6     = 3'd6,
        OPC_RSV7     = 3'd7
    } op_class_e;

    // True for the classes that change stored contents.
    function automatic logic is_modifying(input op_class_e c);
        return (c == OPC_WORD_WR) || (c == OPC_FILL_WR) || (c == OPC_PAGE_WR) ||
               (c == OPC_GREG_WR) || (c == OPC_GREG_CLR);
    endfunction

endpackage

// File: rtl/flg_counter.sv
`timescale 1ns/1ps
// Module: flg_counter
// Counts serial clock edges from the start bit to the chip-select fall.
// The counter saturates at all ones. Assumes at most one event of each kind per cycle.
// A start strobe takes priority over a chip-select fall in the same cycle.
module flg_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_stb,
    input  logic             sclk_stb,
    input  logic             cs_fall_stb,
    output logic             open_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_now,
    output logic             close_evt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // Count including a clock strobe in this cycle, held at the top value.
    always_comb begin
        if (open_q && sclk_stb && (cnt_q != CNT_TOP))
            cnt_now = cnt_q + 1'b1;
        else
            cnt_now = cnt_q;
    end

    // A frame closes on a chip-select fall while it is open.
    always_comb close_evt = open_q && cs_fall_stb && !start_stb;

    // Frame-open flag and the edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_stb) begin
            open_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (close_evt) begin
            open_q <= 1'b0;
        end else if (open_q && sclk_stb) begin
            cnt_q  <= cnt_now;
        end
    end

endmodule

// File: rtl/flg_len_calc.sv
`timescale 1ns/1ps
// Module: flg_len_calc
// Works out the exact frame length for the decoded class and page size.
// Assumes page_words holds the word count minus one.
module flg_len_calc
    import flg_pkg::*;
#(
    parameter int OPC_BITS  = 2,
    parameter int ADDR_BITS = 8,
    parameter int DATA_BITS = 16,
    parameter int PAGE_MAX  = 4,
    parameter int CNT_W     = 7,
    parameter int PW_W      = 2
) (
    input  logic [2:0]       op_class,
    input  logic [PW_W-1:0]  page_words,
    output logic [CNT_W-1:0] exp_len,
    output logic             modifying,
    output logic             len_valid
);
    localparam int HDR_LEN  = 1 + OPC_BITS + ADDR_BITS;
    localparam int WORD_LEN = HDR_LEN + DATA_BITS;

    logic [CNT_W-1:0] page_len [PAGE_MAX];
    op_class_e        cls;

    // One length entry for each page size.
    for (genvar k = 0; k < PAGE_MAX; k++) begin : g_page_len
        assign page_len[k] = CNT_W'(HDR_LEN + DATA_BITS * (k + 1));
    end

    // Pick the expected length for the class.
    always_comb begin
        cls       = op_class_e'(op_class);
        modifying = is_modifying(cls);
        len_valid = 1'b1;
        exp_len   = '0;
        case (cls)
            OPC_WORD_WR, OPC_FILL_WR: exp_len = CNT_W'(WORD_LEN);
            OPC_GREG_WR, OPC_GREG_CLR: exp_len = CNT_W'(HDR_LEN);
            OPC_PAGE_WR: begin
                if (int'(page_words) < PAGE_MAX)
                    exp_len = page_len[int'(page_words)];
                else
                    len_valid = 1'b0;
            end
            default: len_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/flg_verdict.sv
`timescale 1ns/1ps
// Module: flg_verdict
// At frame close, compares the count with the expected length and sends one pulse.
// Assumes close_evt lasts one cycle for each frame.
module flg_verdict #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_evt,
    input  logic             modifying,
    input  logic             len_valid,
    input  logic [CNT_W-1:0] cnt_now,
    input  logic [CNT_W-1:0] exp_len,
    output logic             commit_q,
    output logic             abort_q
);
    logic match;

    // Exact length match for a class that has a defined length.
    always_comb match = len_valid && (cnt_now == exp_len);

    // Registered go or abort pulse to the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            commit_q <= close_evt && modifying && match;
            abort_q  <= close_evt && modifying && !match;
        end
    end

endmodule

// File: rtl/frame_len_guard.sv
`timescale 1ns/1ps
// Module: frame_len_guard (top)
// Clock-count write guard. Counts serial clock edges for each frame and, when chip
// select falls, sends a commit or abort pulse for instructions that change contents.
// Assumes the decoder presents the strobes as one-cycle events in the clk domain.
module frame_len_guard #(
    parameter  int OPC_BITS  = 2,
    parameter  int ADDR_BITS = 8,
    parameter  int DATA_BITS = 16,
    parameter  int PAGE_MAX  = 4,
    localparam int MAX_LEN   = 1 + OPC_BITS + ADDR_BITS + DATA_BITS * PAGE_MAX,
    localparam int CNT_W     = $clog2(MAX_LEN + 2),
    localparam int PW_W      = (PAGE_MAX > 1) ? $clog2(PAGE_MAX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_stb,
    input  logic            sclk_stb,
    input  logic            cs_fall_stb,
    input  logic [2:0]      op_class,
    input  logic [PW_W-1:0] page_words,
    output logic            commit_o,
    output logic            abort_o
);
    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_now;
    logic             close_evt;
    logic [CNT_W-1:0] exp_len;
    logic             modifying;
    logic             len_valid;

    flg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_stb   (start_stb),
        .sclk_stb    (sclk_stb),
        .cs_fall_stb (cs_fall_stb),
        .open_q      (open_q),
        .cnt_q       (cnt_q),
        .cnt_now     (cnt_now),
        .close_evt   (close_evt)
    );

    flg_len_calc #(
        .OPC_BITS  (OPC_BITS),
        .ADDR_BITS (ADDR_BITS),
        .DATA_BITS (DATA_BITS),
        .PAGE_MAX  (PAGE_MAX),
        .CNT_W     (CNT_W),
        .PW_W      (PW_W)
    ) u_len (
        .op_class   (op_class),
        .page_words (page_words),
        .exp_len    (exp_len),
        .modifying  (modifying),
        .len_valid  (len_valid)
    );

    flg_verdict #(.CNT_W(CNT_W)) u_vrd (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_evt (close_evt),
        .modifying (modifying),
        .len_valid (len_valid),
        .cnt_now   (cnt_now),
        .exp_len   (exp_len),
        .commit_q  (commit_o),
        .abort_q   (abort_o)
    );

endmodule

// File: rtl/flg_checker.sv
`timescale 1ns/1ps
// Module: flg_checker
// Property checks for frame_len_guard. Bound into the top module.
module flg_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_stb,
    input logic             cs_fall_stb,
    input logic [2:0]       op_class,
    input logic             commit_o,
    input logic             abort_o,
    input logic             open_q,
    input logic [CNT_W-1:0] cnt_q
);
    p_start_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (open_q && cnt_q == CNT_W'(1)));

    p_excl_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o));

    p_commit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    p_needs_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || abort_o) |-> ($past(rst_n) && $past(cs_fall_stb) && $past(open_q)));

    p_nonmod_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall_stb && (op_class == 3'd0 || op_class == 3'd6 || op_class == 3'd7))
        |=> (!commit_o && !abort_o));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && $past(open_q) && !$past(start_stb)) |-> (cnt_q >= $past(cnt_q)));

endmodule

bind frame_len_guard flg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_stb   (start_stb),
    .cs_fall_stb (cs_fall_stb),
    .op_class    (op_class),
    .commit_o    (commit_o),
    .abort_o     (abort_o),
    .open_q      (open_q),
    .cnt_q       (cnt_q)
);

// File: tb/frame_len_guard_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared with the outputs on every clock.
module frame_len_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_stb, sclk_stb, cs_fall_stb;
    logic [2:0] op_class;
    logic [1:0] page_words;
    logic       commit_o, abort_o;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    string cur    = "R9";
    int    m_open = 0;
    int    m_cnt  = 0;
    logic  exp_c  = 1'b0;
    logic  exp_a  = 1'b0;
    bit    done   = 1'b0;

    always #5 clk = ~clk;

    frame_len_guard u_dut (
        .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .sclk_stb(sclk_stb),
        .cs_fall_stb(cs_fall_stb), .op_class(op_class), .page_words(page_words),
        .commit_o(commit_o), .abort_o(abort_o)
    );

    // Expected frame length from the requirements; -1 means no verdict is due.
    function automatic int ref_len(input logic [2:0] c, input logic [1:0] p);
        case (c)
            3'd1, 3'd2: return 27;              // R2, R3
            3'd3:       return 11 + 16 * (p + 1); // R4
            3'd4, 3'd5: return 11;              // R5
            default:    return -1;              // R7
        endcase
    endfunction

    task automatic step(input logic s, input logic k, input logic f,
                        input logic [2:0] c, input logic [1:0] p);
        start_stb = s; sclk_stb = k; cs_fall_stb = f; op_class = c; page_words = p;
        @(posedge clk);
        exp_c = 1'b0; exp_a = 1'b0;
        if (!rst_n) begin
            m_open = 0;
        end else if (s) begin
            m_open = 1; m_cnt = 1;
        end else if (f && m_open != 0) begin
            int total = m_cnt + (k ? 1 : 0);   // R10
            int want  = ref_len(c, p);
            if (want > 0) begin
                if (total == want) exp_c = 1'b1; else exp_a = 1'b1;  // R6
            end
            m_open = 0;
        end else if (m_open != 0 && k) begin
            m_cnt++;   // the count has no upper limit in the model
        end
        @(negedge clk);
        n_cmp++;
        if (commit_o !== exp_c || abort_o !== exp_a) begin
            n_bad++;
            $display("FAIL %s: commit/abort = %b/%b, expected %b/%b at %0t",
                     cur, commit_o, abort_o, exp_c, exp_a, $time);
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 3'd0, 2'd0);
    endtask

    // One frame of n edges. If merge is set, the last edge shares the cycle with the close.
    task automatic frame(input logic [2:0] c, input logic [1:0] p, input int n,
                         input bit merge, input string tag);
        cur = tag;
        step(1'b1, 1'b1, 1'b0, c, p);
        for (int i = 1; i < n - (merge ? 1 : 0); i++) begin
            step(1'b0, 1'b1, 1'b0, c, p);
            step(1'b0, 1'b0, 1'b0, c, p);
        end
        step(1'b0, merge, 1'b1, c, p);
        idle();
        idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cur = "R9";
        @(negedge clk);
        for (int i = 0; i < 3; i++) idle();     // R9: reset state is all low
        rst_n = 1'b1;
        idle();

        cur = "R1";                             // stray strobes with no frame open
        step(1'b0, 1'b1, 1'b0, 3'd1, 2'd0);
        step(1'b0, 1'b1, 1'b1, 3'd1, 2'd0);
        step(1'b0, 1'b0, 1'b1, 3'd4, 2'd0);
        idle();

        frame(3'd1, 2'd0, 27, 1'b0, "R2");
        frame(3'd1, 2'd0, 26, 1'b0, "R2");
        frame(3'd1, 2'd0, 28, 1'b0, "R6");
        frame(3'd2, 2'd0, 27, 1'b0, "R3");
        frame(3'd2, 2'd0, 28, 1'b0, "R3");
        for (int k = 0; k < 4; k++)
            frame(3'd3, 2'(k), 11 + 16 * (k + 1), 1'b0, "R4");
        frame(3'd3, 2'd3, 59, 1'b0, "R4");
        frame(3'd3, 2'd0, 28, 1'b0, "R6");
        frame(3'd4, 2'd0, 11, 1'b0, "R5");
        frame(3'd5, 2'd0, 11, 1'b0, "R5");
        frame(3'd5, 2'd0, 12, 1'b0, "R5");
        frame(3'd4, 2'd0, 10, 1'b0, "R6");
        frame(3'd0, 2'd0, 27, 1'b0, "R7");
        frame(3'd6, 2'd0, 11, 1'b0, "R7");
        frame(3'd7, 2'd3, 75, 1'b0, "R7");
        frame(3'd3, 2'd3, 203, 1'b0, "R8");     // 203 would wrap a 7-bit count to 75
        frame(3'd3, 2'd3, 200, 1'b0, "R8");
        frame(3'd1, 2'd0, 27, 1'b1, "R10");
        frame(3'd5, 2'd0, 11, 1'b1, "R10");
        frame(3'd2, 2'd0, 26, 1'b1, "R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule